// File: doc/BRIEF.md
# AC'97 Receive Slot FIFO

This block collects 16-bit audio words from the incoming AC'97 link and stores them for a processor or DMA engine to read. An upstream deserialiser presents every slot of a frame in parallel on `slot_data`, with a valid bit per slot on `slot_valid` and a one-cycle `frame_strobe`. On each strobe the block picks either one slot (mono) or two neighbouring slots (stereo) and writes the valid words into an eight-entry FIFO.

A single 16-bit control/status word configures the block. It sets the connection mode, the mono/stereo choice, the slot code, a fill threshold for the level interrupt, and DMA enable. It also shows the full and empty state and a sticky overflow flag that software clears by writing 1. Words are read from the head of the FIFO through `rd_data`/`rd_en`. `irq` and `dma_req` are level signals derived from the fill count.

Top module: `aclink_rx_slot_fifo`

## Requirements
- R1: After reset the control/status word reads 16'h4000 (disconnected, empty flag set), and `irq`, `dma_req` and `rd_data` are 0.
- R2: A write stores bits 1:0 (link mode), bit 3 (stereo), bits 7:4 (slot code), bits 10:8 (threshold T) and bit 11 (DMA enable), which read back in the next cycle. Bits 2 and 12 always read 0, and bits 13, 14 and 15 ignore written data, except that a 1 in bit 15 clears that flag.
- R3: Words are captured only while the link mode is 2'b10. Modes 2'b00, 2'b01 and 2'b11 capture nothing.
- R4: In mono mode (bit 3 = 0), slot codes 3 to 12 capture the slot whose number equals the code, if its `slot_valid` bit is high on the strobe.
- R5: In stereo mode (bit 3 = 1), slot codes 3 to 11 capture slot n and then slot n+1, lower slot first. Each word is gated by its own valid bit.
- R6: Slot codes 0, 1, 2, 13, 14 and 15, and code 12 in stereo mode, capture nothing.
- R7: The FIFO holds 8 words in arrival order. `rd_data` shows the oldest word combinationally, and `rd_en` removes it at the clock edge.
- R8: Bit 13 reads 1 exactly when 8 words are held. Bit 14 reads 1 exactly when none are held.
- R9: A word that finds no free entry is discarded, the stored words stay unchanged, and bit 15 sets. Free space is judged on the count before the edge, so a read in the same cycle makes no room. In stereo mode with one entry free, the lower slot is kept and the upper slot is dropped.
- R10: Bit 15 stays set until a write with bit 15 = 1 clears it. A write with bit 15 = 0 leaves it set. An overflow in the same cycle as a clearing write leaves it set.
- R11: `irq` is high exactly while the FIFO holds at least T+1 words.
- R12: `dma_req` is high exactly while `irq` is high and bit 11 is 1.
- R13: A read while empty returns 0 and changes no state.
- R14: Any link mode other than 2'b10 empties the FIFO by the following cycle. Bit 15 is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the control/status word |
| reg_wdata | input | 16 | Write data for the control/status word |
| reg_rdata | output | 16 | Current control/status word |
| frame_strobe | input | 1 | One-cycle pulse, one per received frame |
| slot_valid | input | 13 | Valid bit per slot 0..12 |
| slot_data | input | 208 | Slot words, slot s at bits 16*s+15:16*s |
| rd_en | input | 1 | Remove the head word |
| rd_data | output | 16 | Head word, 0 when empty |
| irq | output | 1 | Fill count has reached threshold + 1 |
| dma_req | output | 1 | Interrupt condition gated by DMA enable |

## Verification
Two pairs of events can fall on the same edge. An overflowing capture can coincide with a clearing write to bit 15, and a head read can coincide with a capture into a full FIFO. The bench drives `frame_strobe` together with `reg_wr_en` (and separately together with `rd_en`) on one edge. It judges the result from bit 15 and the full flag one cycle later, and from the order of the words that remain. Around these cases, sweeps cover every link mode, mono/stereo choice and slot code, and every threshold at every fill level.

// File: rtl/aclink_rx_pkg.sv
package aclink_rx_pkg;

  typedef enum logic [1:0] {
    LINK_OFF    = 2'b00,
    LINK_RSVD_A = 2'b01,
    LINK_ON     = 2'b10,
    LINK_RSVD_B = 2'b11
  } link_mode_e;

  typedef struct packed {
    logic       dma_en;
    logic [2:0] thresh;
    logic [3:0] slot_code;
    logic       stereo;
    link_mode_e link;
  } rx_cfg_t;

endpackage

// File: rtl/aclink_rx_ctrl_reg.sv
module aclink_rx_ctrl_reg
  import aclink_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  input  logic        fifo_full,
  input  logic        fifo_empty,
  input  logic        overflow_evt,
  output rx_cfg_t     cfg,
  output logic [15:0] rdata
);

  rx_cfg_t cfg_q, cfg_d;
  logic    ovf_q, ovf_d;
  logic    unused_wbits;

  assign unused_wbits = ^{wdata[14:12], wdata[2]};

  // next state
  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.link      = link_mode_e'(wdata[1:0]);
      cfg_d.stereo    = wdata[3];
      cfg_d.slot_code = wdata[7:4];
      cfg_d.thresh    = wdata[10:8];
      cfg_d.dma_en    = wdata[11];
    end
    ovf_d = ovf_q;
    if (overflow_evt) begin
      ovf_d = 1'b1;
    end else if (wr_en && wdata[15]) begin
      ovf_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      ovf_q <= ovf_d;
    end
  end

  assign cfg   = cfg_q;
  assign rdata = {ovf_q, fifo_empty, fifo_full, 1'b0, cfg_q.dma_en,
                  cfg_q.thresh, cfg_q.slot_code, cfg_q.stereo, 1'b0,
                  cfg_q.link};

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[15] && !(wr_en && wdata[15])) |=> rdata[15])
    else $error("overflow flag dropped without a clearing write");

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_evt |=> rdata[15])
    else $error("overflow event did not set the flag");

endmodule

// File: rtl/aclink_rx_slot_pick.sv
module aclink_rx_slot_pick
  import aclink_rx_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int NUM_SLOTS  = 13,
  parameter int FIRST_SLOT = 3
) (
  input  logic                        frame_strobe,
  input  logic [NUM_SLOTS-1:0]        slot_valid,
  input  logic [NUM_SLOTS*WORD_W-1:0] slot_data,
  input  rx_cfg_t                     cfg,
  output logic [1:0]                  lane_we,
  output logic [WORD_W-1:0]           lane_data [2]
);

  localparam int LAST_SLOT = NUM_SLOTS - 1;

  logic code_ok;
  int   base;

  always_comb begin
    base    = int'(cfg.slot_code);
    code_ok = (base >= FIRST_SLOT) &&
              (base <= (cfg.stereo ? LAST_SLOT - 1 : LAST_SLOT));
  end

  for (genvar l = 0; l < 2; l++) begin : g_lane
    int   idx;
    logic lane_on;
    always_comb begin
      idx     = (base + l < NUM_SLOTS) ? base + l : 0;
      lane_on = (l == 0) || cfg.stereo;
      lane_we[l]   = frame_strobe && (cfg.link == LINK_ON) && code_ok &&
                     lane_on && slot_valid[idx];
      lane_data[l] = slot_data[idx*WORD_W +: WORD_W];
    end
  end

endmodule

// File: rtl/aclink_rx_fifo_store.sv
module aclink_rx_fifo_store #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [1:0]        push_we,
  input  logic [WORD_W-1:0] push_data [2],
  input  logic              pop_req,
  output logic [WORD_W-1:0] head_data,
  output logic              full,
  output logic              empty,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic              dropped
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head_q, head_d, tail_q, tail_d, tail_hi;
  logic [CNT_W-1:0]  count_q, count_d, room;
  logic              acc0, acc1, pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // next state
  always_comb begin
    room    = CNT_W'(DEPTH) - count_q;
    acc0    = push_we[0] && !flush && (room != '0);
    acc1    = push_we[1] && !flush &&
              (acc0 ? (room >= CNT_W'(2)) : (room != '0));
    pop     = pop_req && !flush && (count_q != '0);
    dropped = !flush && ((push_we[0] && !acc0) || (push_we[1] && !acc1));
    tail_hi = acc0 ? bump(tail_q) : tail_q;
    tail_d  = acc1 ? bump(tail_hi) : tail_hi;
    head_d  = pop ? bump(head_q) : head_q;
    count_d = count_q + CNT_W'(acc0) + CNT_W'(acc1) - CNT_W'(pop);
    if (flush) begin
      tail_d  = '0;
      head_d  = '0;
      count_d = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  // storage, written only under explicit enables
  always_ff @(posedge clk) begin
    if (acc0) begin
      mem[tail_q] <= push_data[0];
    end
    if (acc1) begin
      mem[tail_hi] <= push_data[1];
    end
  end

  assign empty     = (count_q == '0);
  assign full      = (count_q == CNT_W'(DEPTH));
  assign level     = count_q;
  assign head_data = empty ? '0 : mem[head_q];

  // R8
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty))
    else $error("full and empty together");

  // R7
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH))
    else $error("fill count beyond depth");

  // R13
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && (push_we == 2'b00) && !flush) |=> empty)
    else $error("read of empty store changed state");

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_req && !flush) |=> full)
    else $error("full store lost a word without a read");

  // R14
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty)
    else $error("flush left words behind");

endmodule

// File: rtl/aclink_rx_slot_fifo.sv
module aclink_rx_slot_fifo
  import aclink_rx_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int DEPTH      = 8,
  parameter int NUM_SLOTS  = 13,
  parameter int FIRST_SLOT = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr_en,
  input  logic [15:0]                 reg_wdata,
  output logic [15:0]                 reg_rdata,
  input  logic                        frame_strobe,
  input  logic [NUM_SLOTS-1:0]        slot_valid,
  input  logic [NUM_SLOTS*WORD_W-1:0] slot_data,
  input  logic                        rd_en,
  output logic [WORD_W-1:0]           rd_data,
  output logic                        irq,
  output logic                        dma_req
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  rx_cfg_t           cfg;
  logic [1:0]        lane_we;
  logic [WORD_W-1:0] lane_data [2];
  logic              fifo_full, fifo_empty, dropped, flush;
  logic [CNT_W-1:0]  level;

  assign flush = (cfg.link != LINK_ON);

  aclink_rx_ctrl_reg u_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (reg_wr_en),
    .wdata        (reg_wdata),
    .fifo_full    (fifo_full),
    .fifo_empty   (fifo_empty),
    .overflow_evt (dropped),
    .cfg          (cfg),
    .rdata        (reg_rdata)
  );

  aclink_rx_slot_pick #(
    .WORD_W     (WORD_W),
    .NUM_SLOTS  (NUM_SLOTS),
    .FIRST_SLOT (FIRST_SLOT)
  ) u_pick (
    .frame_strobe (frame_strobe),
    .slot_valid   (slot_valid),
    .slot_data    (slot_data),
    .cfg          (cfg),
    .lane_we      (lane_we),
    .lane_data    (lane_data)
  );

  aclink_rx_fifo_store #(
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push_we   (lane_we),
    .push_data (lane_data),
    .pop_req   (rd_en),
    .head_data (rd_data),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .level     (level),
    .dropped   (dropped)
  );

  always_comb begin
    irq     = int'(level) > int'(cfg.thresh);
    dma_req = irq && cfg.dma_en;
  end

  // R3
  link_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |-> (reg_rdata[1:0] == 2'b10))
    else $error("capture while link not connected");

  // R5
  lane_stereo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_we[1] |-> reg_rdata[3])
    else $error("second lane used in mono mode");

  // R11
  irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !reg_rdata[14])
    else $error("interrupt while empty");

  // R12
  dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[11] |-> !dma_req)
    else $error("DMA request with DMA disabled");

endmodule

// File: tb/tb_aclink_rx_slot_fifo.sv
module tb_aclink_rx_slot_fifo;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr_en;
  logic [15:0]   reg_wdata;
  logic [15:0]   reg_rdata;
  logic          frame_strobe;
  logic [12:0]   slot_valid;
  logic [207:0]  slot_data;
  logic          rd_en;
  logic [15:0]   rd_data;
  logic          irq;
  logic          dma_req;

  int checks = 0;
  int errors = 0;
  logic [7:0] frm_id = 8'h10;

  always #5 clk = ~clk;

  aclink_rx_slot_fifo dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .frame_strobe (frame_strobe),
    .slot_valid   (slot_valid),
    .slot_data    (slot_data),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .irq          (irq),
    .dma_req      (dma_req)
  );

  function automatic logic [15:0] word_of(input logic [7:0] f, input int s);
    return {f, 4'hA, 4'(s)};
  endfunction

  function automatic logic [15:0] mk_cfg(input logic [1:0] ce, input logic sm,
                                          input logic [3:0] code,
                                          input logic [2:0] t, input logic dme);
    return {4'b0000, dme, t, code, sm, 1'b0, ce};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: all inputs driven at a falling edge, released at the next
  task automatic cycle(input logic strobe, input logic [12:0] mask,
                       input logic wr, input logic [15:0] wv, input logic rd);
    for (int s = 0; s < 13; s++) slot_data[s*16 +: 16] = word_of(frm_id, s);
    frame_strobe = strobe;
    slot_valid   = mask;
    reg_wr_en    = wr;
    reg_wdata    = wv;
    rd_en        = rd;
    @(negedge clk);
    if (strobe) frm_id = frm_id + 8'd1;
    frame_strobe = 1'b0;
    slot_valid   = '0;
    reg_wr_en    = 1'b0;
    rd_en        = 1'b0;
  endtask

  task automatic wr_reg(input logic [15:0] v);
    cycle(1'b0, '0, 1'b1, v, 1'b0);
  endtask

  task automatic frame(input logic [12:0] mask);
    cycle(1'b1, mask, 1'b0, 16'h0, 1'b0);
  endtask

  task automatic pop_one(output logic [15:0] got);
    got = rd_data;
    cycle(1'b0, '0, 1'b0, 16'h0, 1'b1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] got, snap, cfg_a;
    logic [7:0]  f0, f;
    rst_n = 1'b0;
    reg_wr_en = 1'b0; reg_wdata = '0; frame_strobe = 1'b0;
    slot_valid = '0; slot_data = '0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 reg", reg_rdata, 16'h4000);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 dma", {15'b0, dma_req}, 16'h0);
    chk("R1 rd_data", rd_data, 16'h0);

    // R2 field storage and constant bits
    wr_reg(16'hFFFF); chk("R2 all ones", reg_rdata, 16'h4FFB);
    wr_reg(16'h75A5); chk("R2 pattern", reg_rdata, 16'h45A1);
    wr_reg(16'h0A5A); chk("R2 pattern2", reg_rdata, 16'h4A5A);
    wr_reg(16'h0000); chk("R2 zero", reg_rdata, 16'h4000);

    // R3 R4 R5 R6 sweep over link mode, mono/stereo and slot code
    for (int ce = 0; ce < 4; ce++) begin
      for (int sm = 0; sm < 2; sm++) begin
        for (int code = 0; code < 16; code++) begin
          logic  legal;
          int    n;
          string tag;
          legal = (code >= 3) && ((sm == 1) ? code <= 11 : code <= 12);
          n = (ce == 2 && legal) ? sm + 1 : 0;
          tag = (ce != 2) ? "R3" : (!legal ? "R6" : ((sm == 1) ? "R5" : "R4"));
          wr_reg(mk_cfg(ce[1:0], sm[0], code[3:0], 3'd7, 1'b0));
          f = frm_id;
          frame(13'h1FFF);
          chk({tag, " empty after frame"}, {15'b0, reg_rdata[14]}, (n == 0) ? 16'h1 : 16'h0);
          for (int k = 0; k < n; k++) begin
            pop_one(got);
            chk({tag, " word"}, got, word_of(f, code + k));
          end
          chk({tag, " drained"}, {15'b0, reg_rdata[14]}, 16'h1);
          wr_reg(16'h0000);
        end
      end
    end

    // R5 per-slot valid gating in stereo
    wr_reg(mk_cfg(2'b10, 1'b1, 4'd5, 3'd7, 1'b0));
    f = frm_id; frame(13'h0040);
    pop_one(got); chk("R5 upper only", got, word_of(f, 6));
    chk("R5 one word", {15'b0, reg_rdata[14]}, 16'h1);
    f = frm_id; frame(13'h0020);
    pop_one(got); chk("R5 lower only", got, word_of(f, 5));
    chk("R5 one word b", {15'b0, reg_rdata[14]}, 16'h1);
    // R4 gating in mono
    wr_reg(mk_cfg(2'b10, 1'b0, 4'd9, 3'd7, 1'b0));
    frame(13'h1DFF);
    chk("R4 invalid slot ignored", {15'b0, reg_rdata[14]}, 16'h1);
    wr_reg(16'h0000);

    // R11 R12 R8 R7 threshold sweep at every fill level
    for (int t = 0; t < 8; t++) begin
      logic dme;
      dme = t[0];
      wr_reg(mk_cfg(2'b10, 1'b0, 4'd3, t[2:0], dme));
      f0 = frm_id;
      for (int n = 1; n <= 8; n++) begin
        frame(13'h0008);
        chk("R11 irq", {15'b0, irq}, (n >= t + 1) ? 16'h1 : 16'h0);
        chk("R12 dma", {15'b0, dma_req}, (dme && n >= t + 1) ? 16'h1 : 16'h0);
        chk("R8 full", {15'b0, reg_rdata[13]}, (n == 8) ? 16'h1 : 16'h0);
      end
      for (int k = 0; k < 8; k++) begin
        pop_one(got);
        chk("R7 order", got, word_of(f0 + 8'(k), 3));
      end
      chk("R8 empty", {15'b0, reg_rdata[14]}, 16'h1);
      wr_reg(16'h0000);
    end

    // R9 overflow while full
    cfg_a = mk_cfg(2'b10, 1'b0, 4'd4, 3'd7, 1'b0);
    wr_reg(cfg_a);
    f0 = frm_id;
    for (int k = 0; k < 8; k++) frame(13'h0010);
    chk("R8 full set", {15'b0, reg_rdata[13]}, 16'h1);
    frame(13'h0010);
    chk("R9 flag set", {15'b0, reg_rdata[15]}, 16'h1);
    chk("R9 head kept", rd_data, word_of(f0, 4));
    // R10 overflow and clear on the same edge
    cycle(1'b1, 13'h0010, 1'b1, cfg_a | 16'h8000, 1'b0);
    chk("R10 set wins", {15'b0, reg_rdata[15]}, 16'h1);
    wr_reg(cfg_a | 16'h8000);
    chk("R10 cleared", {15'b0, reg_rdata[15]}, 16'h0);
    // R9 read and capture on the same edge while full
    cycle(1'b1, 13'h0010, 1'b0, 16'h0, 1'b1);
    chk("R9 no room from read", {15'b0, reg_rdata[13]}, 16'h0);
    chk("R9 flag on collide", {15'b0, reg_rdata[15]}, 16'h1);
    wr_reg(cfg_a);
    chk("R10 zero write keeps", {15'b0, reg_rdata[15]}, 16'h1);
    for (int k = 1; k < 8; k++) begin
      pop_one(got);
      chk("R9 contents kept", got, word_of(f0 + 8'(k), 4));
    end

    // R13 empty read
    snap = reg_rdata;
    chk("R13 zero data", rd_data, 16'h0);
    pop_one(got);
    chk("R13 read value", got, 16'h0);
    chk("R13 reg unchanged", reg_rdata, snap);
    chk("R13 no irq", {15'b0, irq}, 16'h0);
    frame(13'h0010);
    chk("R13 next word intact", rd_data, word_of(frm_id - 8'd1, 4));

    // R14 disable flushes, overflow kept
    frame(13'h0010); frame(13'h0010);
    wr_reg(16'h0000);
    @(negedge clk);
    chk("R14 flushed", {15'b0, reg_rdata[14]}, 16'h1);
    chk("R14 flag kept", {15'b0, reg_rdata[15]}, 16'h1);
    wr_reg(cfg_a);
    chk("R14 still empty", {15'b0, reg_rdata[14]}, 16'h1);
    chk("R14 data zero", rd_data, 16'h0);

    // R9 stereo pair with one free entry
    wr_reg(cfg_a | 16'h8000);
    f0 = frm_id;
    for (int k = 0; k < 7; k++) frame(13'h0010);
    wr_reg(mk_cfg(2'b10, 1'b1, 4'd7, 3'd7, 1'b0));
    chk("R9 no flag yet", {15'b0, reg_rdata[15]}, 16'h0);
    f = frm_id;
    frame(13'h1FFF);
    chk("R9 stereo full", {15'b0, reg_rdata[13]}, 16'h1);
    chk("R9 stereo flag", {15'b0, reg_rdata[15]}, 16'h1);
    for (int k = 0; k < 7; k++) begin
      pop_one(got);
      chk("R9 stereo older", got, word_of(f0 + 8'(k), 4));
    end
    pop_one(got);
    chk("R9 lower kept", got, word_of(f, 7));
    chk("R9 upper dropped", {15'b0, reg_rdata[14]}, 16'h1);

    finish_run();
  end

endmodule